// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block picks which page frame to give up when a new page must be brought into memory. It keeps a one-bit "recently used" mark for each of a fixed number of frames, arranged in a ring, and a hand that points at one frame. Each frame's mark is set whenever that frame is touched. When an eviction is requested, the hand sweeps forward one frame per clock. A frame whose mark is clear becomes the victim. A frame whose mark is set loses its mark and is passed over, which gives it one more round before it can be chosen.

After a victim is chosen, the hand moves one place past it. When the replacement page has been installed, a load-complete strobe sets the victim frame's mark. The new page therefore sits just behind the hand and is the last frame examined on the next sweep. The surrounding memory manager drives the touch strobes and the eviction requests. It reads back the victim index on the done strobe and then reports the load-complete.

Top module: `clock_evictor`

## Requirements
- R1: After a synchronous active-low reset, the hand is at frame 0, the done strobe is low, the victim index is 0 and every mark is clear, so a first request chooses frame 0.
- R2: A high bit `i` of `ref_pulse` at a clock edge sets the mark of frame `i`. A later sweep that reaches frame `i` passes over it.
- R3: A request accepted while idle inspects the frame under the hand at that same edge. If that mark is clear, `evict_done` is high in the following cycle with `victim_idx` equal to that frame.
- R4: Each inspection of a frame whose mark is set clears that mark and advances the hand by exactly one frame, wrapping from N_FRAMES-1 to 0. Only one frame is inspected per clock.
- R5: When a victim is chosen, the hand moves to the frame one past the victim in the same edge.
- R6: If every mark is set and no touch arrives during the sweep, all marks are cleared and the frame where the sweep started is chosen. `evict_done` then rises N_FRAMES+1 cycles after the request edge.
- R7: `load_done` sets the mark of the frame last reported on `victim_idx`, so the next sweep passes over that frame once.
- R8: When a touch and a sweep clear hit the same frame in the same cycle, the mark ends up set.
- R9: `evict_req` is ignored while a sweep is in progress. Holding it high during a sweep neither restarts nor lengthens the sweep, and it does not produce a second done strobe.
- R10: `evict_done` is high for one cycle per chosen victim and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_pulse | input | N_FRAMES | One-cycle touch strobe per frame |
| evict_req | input | 1 | Request for a victim; sampled only while idle |
| load_done | input | 1 | New page installed in the last victim frame |
| victim_idx | output | $clog2(N_FRAMES) | Frame chosen by the latest sweep |
| evict_done | output | 1 | One-cycle strobe marking a new victim |
| hand_pos | output | $clog2(N_FRAMES) | Current hand position |

## Verification
Every result of this block is registered, so a touch, a load strobe or an inspection affects the marks and the hand at the very next edge. A sweep that finds k set marks ahead of the hand raises `evict_done` k+1 cycles after the request edge. The bench drives inputs on the falling edge and runs a cycle model of the requirements at that moment. After the following falling edge it compares the hand, the done strobe and, when done is high, the victim index, so each expected value is due exactly one edge after its stimulus. Directed sweeps also count the cycles between the request and the done strobe and compare that count with the k+1 rule, including the N_FRAMES+1 worst case.

// File: rtl/clock_evictor_pkg.sv
// Shared types for the clock victim selector.
package clock_evictor_pkg;
    // Sweep controller states.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;
endpackage

// File: rtl/frame_mark_array.sv
// Holds one "recently used" mark per frame.
// Assumes: at most one clear per cycle (at the hand). A set from a touch or
// from a load always wins over a clear in the same cycle.
module frame_mark_array #(
    parameter int N_FRAMES = 8,
    localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_FRAMES-1:0] touch,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    input  logic                load_en,
    input  logic [IDX_W-1:0]    load_idx,
    output logic [N_FRAMES-1:0] marks
);
    for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
        logic set_hit;
        logic clr_hit;

        // Decode whether this frame is set or cleared this cycle.
        always_comb begin
            set_hit = touch[g] | (load_en && (load_idx == IDX_W'(g)));
            clr_hit = clr_en && (clr_idx == IDX_W'(g));
        end

        // Update the mark, with set taking priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)       marks[g] <= 1'b0;
            else if (set_hit) marks[g] <= 1'b1;
            else if (clr_hit) marks[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/hand_ring.sv
// Hand pointer that walks the ring of frames one step per enabled cycle.
// Assumes: a step is requested at most once per clock.
module hand_ring #(
    parameter int N_FRAMES = 8,
    localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [IDX_W-1:0] hand
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

    // Advance the hand with a wrap back to frame 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       hand <= '0;
        else if (step_en) hand <= (hand == LAST) ? '0 : hand + 1'b1;
    end
endmodule

// File: rtl/sweep_ctrl.sv
// Sweep controller: accepts a request when idle and inspects one frame per
// cycle. It clears set marks and records the first clear frame as the victim.
// Assumes: cur_mark is the mark of the frame under the hand in this cycle.
module sweep_ctrl
    import clock_evictor_pkg::*;
#(
    parameter int N_FRAMES = 8,
    localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evict_req,
    input  logic             cur_mark,
    input  logic [IDX_W-1:0] hand,
    output logic             inspect,
    output logic             clr_en,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim
);
    sweep_state_e state;
    logic         pick;

    // Decide whether a frame is inspected this cycle and what happens to it.
    always_comb begin
        inspect = (state == ST_SWEEP) || evict_req;
        clr_en  = inspect && cur_mark;
        pick    = inspect && !cur_mark;
        busy    = (state == ST_SWEEP);
    end

    // State register: stay in the sweep until a clear mark is found.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (pick)   state <= ST_IDLE;
        else if (clr_en) state <= ST_SWEEP;
    end

    // Register the done strobe and the chosen frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            victim <= '0;
        end else begin
            done <= pick;
            if (pick) victim <= hand;
        end
    end
endmodule

// File: rtl/clock_evictor.sv
// Top of the clock victim selector: wires together the marks, the hand and
// the sweep controller.
// Assumes: load_done refers to the frame most recently shown on victim_idx.
module clock_evictor #(
    parameter int N_FRAMES = 8,
    localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_FRAMES-1:0] ref_pulse,
    input  logic                evict_req,
    input  logic                load_done,
    output logic [IDX_W-1:0]    victim_idx,
    output logic                evict_done,
    output logic [IDX_W-1:0]    hand_pos
);
    logic [N_FRAMES-1:0] ref_bits;
    logic                cur_mark;
    logic                inspect;
    logic                clr_en;
    logic                busy;

    // Select the mark under the hand.
    always_comb cur_mark = ref_bits[hand_pos];

    frame_mark_array #(.N_FRAMES(N_FRAMES)) u_marks (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch    (ref_pulse),
        .clr_en   (clr_en),
        .clr_idx  (hand_pos),
        .load_en  (load_done),
        .load_idx (victim_idx),
        .marks    (ref_bits)
    );

    hand_ring #(.N_FRAMES(N_FRAMES)) u_hand (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (inspect),
        .hand    (hand_pos)
    );

    sweep_ctrl #(.N_FRAMES(N_FRAMES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evict_req (evict_req),
        .cur_mark  (cur_mark),
        .hand      (hand_pos),
        .inspect   (inspect),
        .clr_en    (clr_en),
        .busy      (busy),
        .done      (evict_done),
        .victim    (victim_idx)
    );
endmodule

// File: rtl/clock_evictor_chk.sv
// Checker for the clock victim selector, attached to every instance by bind.
// Assumes: it is bound to clock_evictor, whose internals it observes.
module clock_evictor_chk #(
    parameter int N_FRAMES = 8,
    localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_FRAMES-1:0] ref_pulse,
    input logic                load_done,
    input logic                evict_done,
    input logic [IDX_W-1:0]    victim_idx,
    input logic [IDX_W-1:0]    hand_pos,
    input logic [N_FRAMES-1:0] ref_bits,
    input logic                busy
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

    // R2 and R8: a touched frame has its mark set on the next cycle.
    a_r2_touch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|ref_pulse) |=> ((ref_bits & $past(ref_pulse)) == $past(ref_pulse)));

    // R4: the hand only ever moves one step forward.
    a_r4_hand_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hand_pos != $past(hand_pos)) |->
        (hand_pos == (($past(hand_pos) == LAST) ? '0 : $past(hand_pos) + 1'b1)));

    // R5: while done is high, the hand sits one past the victim.
    a_r5_hand_past_victim: assert property (@(posedge clk) disable iff (!rst_n)
        evict_done |-> (hand_pos == ((victim_idx == LAST) ? '0 : victim_idx + 1'b1)));

    // R7: a load strobe sets the mark of the reported victim.
    a_r7_load_sets_mark: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> ref_bits[$past(victim_idx)]);

    // R10: a done strobe means the sweep has already ended.
    a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        evict_done |-> !busy);
endmodule

bind clock_evictor clock_evictor_chk #(.N_FRAMES(N_FRAMES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_pulse  (ref_pulse),
    .load_done  (load_done),
    .evict_done (evict_done),
    .victim_idx (victim_idx),
    .hand_pos   (hand_pos),
    .ref_bits   (ref_bits),
    .busy       (busy)
);

// File: tb/clock_evictor_tb.sv
module clock_evictor_tb;
    localparam int N = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ref_pulse = '0;
    logic          evict_req = 1'b0;
    logic          load_done = 1'b0;
    logic [IW-1:0] victim_idx;
    logic          evict_done;
    logic [IW-1:0] hand_pos;

    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;
    string tag = "R1";

    // Cycle model of the requirements.
    logic [N-1:0] m_ref;
    int m_hand, m_victim;
    bit m_busy, m_done;

    clock_evictor #(.N_FRAMES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .evict_req(evict_req),
        .load_done(load_done), .victim_idx(victim_idx), .evict_done(evict_done),
        .hand_pos(hand_pos)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 100000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    function automatic int nxt(int h);
        return (h + 1) % N;
    endfunction

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the model, then compare after the edge.
    task automatic step(bit req, logic [N-1:0] pul, bit ld);
        logic [N-1:0] nref;
        bit insp;
        evict_req = req; ref_pulse = pul; load_done = ld;
        insp = m_busy || req;
        nref = m_ref;
        if (insp && m_ref[m_hand]) nref[m_hand] = 1'b0;
        nref = nref | pul;
        if (ld) nref[m_victim] = 1'b1;
        m_done = 1'b0;
        if (insp) begin
            if (m_ref[m_hand]) m_busy = 1'b1;
            else begin
                m_done = 1'b1; m_victim = m_hand; m_busy = 1'b0;
            end
            m_hand = nxt(m_hand);
        end
        m_ref = nref;
        @(negedge clk);
        evict_req = 1'b0; ref_pulse = '0; load_done = 1'b0;
        check("R10 done strobe", int'(evict_done), int'(m_done));
        check("R4 hand position", int'(hand_pos), m_hand);
        if (m_done) check("R3 victim index", int'(victim_idx), m_victim);
    endtask

    // Issue a request and, with req_hold set, keep requesting until done.
    task automatic evict(bit req_hold, output int lat, output int vic, output int dones);
        step(1'b1, '0, 1'b0);
        lat = 1;
        dones = int'(evict_done);
        while (!evict_done && lat < 4 * N) begin
            step(req_hold, '0, 1'b0);
            lat++;
            dones += int'(evict_done);
        end
        vic = int'(victim_idx);
    endtask

    initial begin
        int lat, vic, dn, start, h0;
        void'($urandom(32'h5eed_c10c));
        m_ref = '0; m_hand = 0; m_victim = 0; m_busy = 0; m_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        tag = "R1";
        check("R1 hand after reset", int'(hand_pos), 0);
        check("R1 done after reset", int'(evict_done), 0);

        tag = "R3";
        evict(1'b0, lat, vic, dn);
        check("R1 first victim", vic, 0);
        check("R3 latency", lat, 1);
        check("R5 hand past victim", int'(hand_pos), 1);

        tag = "R7";
        step(1'b0, '0, 1'b1);                 // frame 0 marked by the load
        step(1'b0, {{(N-1){1'b1}}, 1'b0}, 1'b0);
        evict(1'b0, lat, vic, dn);
        check("R7 loaded frame passed over", vic, 1);
        check("R7 latency", lat, N + 1);

        tag = "R6";
        start = int'(hand_pos);
        step(1'b0, '1, 1'b0);
        evict(1'b0, lat, vic, dn);
        check("R6 victim is start frame", vic, start);
        check("R6 latency", lat, N + 1);

        tag = "R8";
        h0 = int'(hand_pos);
        step(1'b0, '1, 1'b0);
        step(1'b1, '0, 1'b0);                 // clears h0
        step(1'b0, N'(1) << nxt(h0), 1'b0);   // touch the frame being cleared
        while (!evict_done) step(1'b0, '0, 1'b0);
        check("R8 first victim", int'(victim_idx), h0);
        evict(1'b0, lat, vic, dn);
        check("R8 touched frame kept", vic, nxt(nxt(h0)));

        tag = "R9";
        start = int'(hand_pos);
        step(1'b0, '1, 1'b0);
        evict(1'b1, lat, vic, dn);
        check("R9 latency with held request", lat, N + 1);
        check("R9 single done", dn, 1);
        check("R9 victim", vic, start);

        tag = "R2";
        start = int'(hand_pos);
        step(1'b0, N'(1) << start, 1'b0);
        evict(1'b0, lat, vic, dn);
        check("R2 touched frame skipped", vic, nxt(start));
        check("R2 latency", lat, 2);

        tag = "R4 R5 R10 random";
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] p;
            p = N'($urandom) & N'($urandom) & N'($urandom);
            step(($urandom % 4) == 0, p, ($urandom % 8) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule